// File: doc/BRIEF.md
# Banked Scratch RAM with Register, Direct and Pointer Access

This block holds the 128-byte internal scratch memory of a small 8-bit controller. It offers three ways to reach a byte. A register access names one of eight working registers. The two bank-select bits from the processor status word move that register into one of four 8-byte windows. A direct access names a byte address and ignores the bank selection. A pointer access first reads working register 0 or 1 of the active bank. It then uses the value read as the address of the byte to read or write.

A request is accepted on a rising edge when `req_valid` is high and the block is not busy. Register and direct accesses finish at the accepting edge. Pointer accesses need a second cycle, and `busy` is high during that cycle. The control is a two-state machine. `ST_IDLE` accepts requests and stays in `ST_IDLE` for everything except an accepted pointer request. The transition `ST_IDLE -> ST_IND` happens when a pointer request is accepted, and it latches the pointer value. The transition `ST_IND -> ST_IDLE` always happens on the next edge and performs the access at the latched pointer. Reads report on `rd_valid`/`rd_data` and writes report on `wr_ack`, in the cycle after the edge that did the work.

Top module: `bank_ram`

## Requirements
- R1: While and right after reset, `busy`, `rd_valid` and `wr_ack` are low.
- R2: Mode 2'b00 (register) targets byte address 8*`bank_sel` + `reg_num`. A read there returns the byte with `rd_valid` high in the cycle after acceptance.
- R3: Mode 2'b01 (direct) targets byte address `dir_addr` whatever `bank_sel` is, so every register of every bank (0x00..0x1F) is reachable directly.
- R4: A write in register or direct mode stores `wdata` at the accepting edge. `wr_ack` is high for the single following cycle, with `rd_valid` low.
- R5: Mode 2'b10 (pointer) reads the register at offset `ptr_sel` (0 or 1) of the active bank and uses its value as the target address. The read result or write acknowledge appears two cycles after acceptance.
- R6: `busy` is high for exactly the one cycle after a pointer request is accepted. A request offered while `busy` is high is dropped and changes neither memory nor outputs.
- R7: A direct address or pointer value with bit 7 set lies outside the array. A read of it returns 0x00 with `rd_valid`. A write to it is acknowledged and leaves memory unchanged.
- R8: `bank_sel` is sampled only at acceptance. A change during the busy cycle does not affect the pointer access in flight, and the new value applies to the next accepted request.
- R9: Mode 2'b11 is reserved. Such a request is accepted but writes nothing and raises neither `rd_valid` nor `wr_ack`.
- R10: `rd_data` keeps the last read result while no new read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | 00 register, 01 direct, 10 pointer, 11 reserved |
| req_write | input | 1 | 1 = write, 0 = read |
| reg_num | input | 3 | Working register number for register mode |
| dir_addr | input | 8 | Byte address for direct mode |
| ptr_sel | input | 1 | Pointer register choice: 0 = register 0, 1 = register 1 |
| wdata | input | 8 | Write data |
| bank_sel | input | 2 | Active bank from the status word |
| busy | output | 1 | Pointer access in its second cycle; requests are dropped |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_data | output | 8 | Read result |
| wr_ack | output | 1 | Write completed (one-cycle pulse) |

## Verification
The hardest situation to reach is a pointer access in flight while the inputs change under it. In that situation the bank selection moves and a competing request arrives during the busy cycle. The stimulus loads a pointer register in bank 2. It then issues a pointer read and, in the next cycle, switches `bank_sel` to 0 and offers a direct write. The result must still come from the bank-2 pointer, and a later read of the write's target must show the dropped write left the byte unchanged. Out-of-range pointers are reached by first storing a value with bit 7 set into a pointer register through register mode.

// File: rtl/bank_ram_pkg.sv
package bank_ram_pkg;

    typedef enum logic [1:0] {
        MODE_REG = 2'b00,
        MODE_DIR = 2'b01,
        MODE_IND = 2'b10,
        MODE_RSV = 2'b11
    } acc_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_IND  = 1'b1
    } ctl_state_t;

endpackage

// File: rtl/bank_ram_addr.sv
module bank_ram_addr
    import bank_ram_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int REG_W  = 3,
    parameter int ADDR_W = 7,
    localparam int PA_W  = ADDR_W + 1
) (
    input  acc_mode_t               mode,
    input  logic [REG_W-1:0]        reg_num,
    input  logic [PA_W-1:0]         dir_addr,
    input  logic                    ptr_sel,
    input  logic [BANK_W-1:0]       bank_sel,
    output logic [PA_W-1:0]         phys_addr,
    output logic [ADDR_W-1:0]       ptr_addr
);

    // Register window: bank number above the register index.
    logic [PA_W-1:0] reg_addr;

    assign reg_addr = PA_W'({bank_sel, reg_num});
    assign ptr_addr = ADDR_W'({bank_sel, {(REG_W-1){1'b0}}, ptr_sel});

    always_comb begin
        unique case (mode)
            MODE_REG: phys_addr = reg_addr;
            default:  phys_addr = dir_addr;
        endcase
    end

endmodule

// File: rtl/bank_ram_array.sv
module bank_ram_array #(
    parameter int DW     = 8,
    parameter int DEPTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DW-1:0]     acc_wdata,
    output logic [DW-1:0]     acc_rdata,
    input  logic [ADDR_W-1:0] ptr_addr,
    output logic [DW-1:0]     ptr_rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[acc_addr] <= acc_wdata;
        end
    end

    assign acc_rdata = mem[acc_addr];
    assign ptr_rdata = mem[ptr_addr];

endmodule

// File: rtl/bank_ram_fsm.sv
module bank_ram_fsm
    import bank_ram_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 128,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PA_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  acc_mode_t         req_mode,
    input  logic              req_write,
    input  logic [DW-1:0]     req_wdata,
    input  logic [PA_W-1:0]   phys_addr,
    input  logic [DW-1:0]     ptr_rdata,
    input  logic [DW-1:0]     mem_rdata,
    output logic [ADDR_W-1:0] mem_idx,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic              busy,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              wr_ack
);

    ctl_state_t    state, state_nx;
    logic [DW-1:0] ptr_q;
    logic          wr_q;
    logic [DW-1:0] wdata_q;

    logic            accept;
    logic            do_access;
    logic            cur_write;
    logic            in_range;
    logic [PA_W-1:0] mem_addr;

    assign accept    = req_valid && (state == ST_IDLE);
    assign busy      = (state == ST_IND);
    assign mem_addr  = (state == ST_IND) ? PA_W'(ptr_q) : phys_addr;
    assign in_range  = (mem_addr < PA_W'(DEPTH));
    assign mem_idx   = mem_addr[ADDR_W-1:0];
    assign cur_write = (state == ST_IND) ? wr_q : req_write;
    assign mem_wdata = (state == ST_IND) ? wdata_q : req_wdata;
    assign do_access = (state == ST_IND) ||
                       (accept && (req_mode == MODE_REG || req_mode == MODE_DIR));
    assign mem_we    = do_access && cur_write && in_range;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept && req_mode == MODE_IND) state_nx = ST_IND;
            ST_IND:  state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            wr_q     <= 1'b0;
            wdata_q  <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            wr_ack   <= 1'b0;
        end else begin
            rd_valid <= do_access && !cur_write;
            wr_ack   <= do_access && cur_write;
            if (do_access && !cur_write) begin
                rd_data <= in_range ? mem_rdata : '0;
            end
            if (accept && req_mode == MODE_IND) begin
                ptr_q   <= ptr_rdata;
                wr_q    <= req_write;
                wdata_q <= req_wdata;
            end
        end
    end

    // R5
    ind_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode == MODE_IND) |=> busy);

    // R6
    busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    // R7
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_access && !cur_write && !in_range) |=> (rd_valid && rd_data == '0));

    // R4
    ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && wr_ack));

    // R9
    rsv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_mode == MODE_RSV) |=> (!rd_valid && !wr_ack && !busy));

endmodule

// File: rtl/bank_ram.sv
module bank_ram
    import bank_ram_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DEPTH  = 128,
    parameter int BANK_W = 2,
    parameter int REG_W  = 3,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PA_W   = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic              req_write,
    input  logic [REG_W-1:0]  reg_num,
    input  logic [PA_W-1:0]   dir_addr,
    input  logic              ptr_sel,
    input  logic [DW-1:0]     wdata,
    input  logic [BANK_W-1:0] bank_sel,
    output logic              busy,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              wr_ack
);

    acc_mode_t         mode;
    logic [PA_W-1:0]   phys_addr;
    logic [ADDR_W-1:0] ptr_addr;
    logic [ADDR_W-1:0] mem_idx;
    logic              mem_we;
    logic [DW-1:0]     mem_wdata;
    logic [DW-1:0]     mem_rdata;
    logic [DW-1:0]     ptr_rdata;

    assign mode = acc_mode_t'(req_mode);

    bank_ram_addr #(
        .BANK_W (BANK_W),
        .REG_W  (REG_W),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .mode      (mode),
        .reg_num   (reg_num),
        .dir_addr  (dir_addr),
        .ptr_sel   (ptr_sel),
        .bank_sel  (bank_sel),
        .phys_addr (phys_addr),
        .ptr_addr  (ptr_addr)
    );

    bank_ram_array #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_array (
        .clk       (clk),
        .we        (mem_we),
        .acc_addr  (mem_idx),
        .acc_wdata (mem_wdata),
        .acc_rdata (mem_rdata),
        .ptr_addr  (ptr_addr),
        .ptr_rdata (ptr_rdata)
    );

    bank_ram_fsm #(
        .DW    (DW),
        .DEPTH (DEPTH)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mode  (mode),
        .req_write (req_write),
        .req_wdata (wdata),
        .phys_addr (phys_addr),
        .ptr_rdata (ptr_rdata),
        .mem_rdata (mem_rdata),
        .mem_idx   (mem_idx),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .wr_ack    (wr_ack)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !rd_valid && !wr_ack));

endmodule

// File: tb/bank_ram_bench.sv
module bank_ram_bench;

    typedef struct packed {
        logic [1:0] mode;
        logic       wr;
        logic [1:0] bank;
        logic [2:0] rn;
        logic [7:0] addr;
        logic       sel;
        logic [7:0] wd;
        logic [7:0] exp;
        logic [3:0] rq;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t VECS [NVEC] = '{
        '{2'd1, 1'b1, 2'd0, 3'd0, 8'h40, 1'b0, 8'h3C, 8'h00, 4'd4},  // R4
        '{2'd0, 1'b1, 2'd1, 3'd5, 8'h00, 1'b0, 8'hA5, 8'h00, 4'd2},  // R2 -> 0x0D
        '{2'd1, 1'b0, 2'd0, 3'd0, 8'h0D, 1'b0, 8'h00, 8'hA5, 4'd3},  // R3
        '{2'd0, 1'b1, 2'd2, 3'd0, 8'h00, 1'b0, 8'h40, 8'h00, 4'd2},  // R2 -> 0x10
        '{2'd0, 1'b1, 2'd2, 3'd1, 8'h00, 1'b0, 8'h0D, 8'h00, 4'd2},  // R2 -> 0x11
        '{2'd2, 1'b0, 2'd2, 3'd0, 8'h00, 1'b0, 8'h00, 8'h3C, 4'd5},  // R5
        '{2'd2, 1'b0, 2'd2, 3'd0, 8'h00, 1'b1, 8'h00, 8'hA5, 4'd5},  // R5
        '{2'd2, 1'b1, 2'd2, 3'd0, 8'h00, 1'b0, 8'h77, 8'h00, 4'd5},  // R5
        '{2'd1, 1'b0, 2'd0, 3'd0, 8'h40, 1'b0, 8'h00, 8'h77, 4'd5},  // R5
        '{2'd0, 1'b1, 2'd3, 3'd7, 8'h00, 1'b0, 8'h5A, 8'h00, 4'd2},  // R2 -> 0x1F
        '{2'd0, 1'b1, 2'd0, 3'd7, 8'h00, 1'b0, 8'h11, 8'h00, 4'd2},  // R2 -> 0x07
        '{2'd0, 1'b0, 2'd3, 3'd7, 8'h00, 1'b0, 8'h00, 8'h5A, 4'd2},  // R2
        '{2'd0, 1'b0, 2'd0, 3'd7, 8'h00, 1'b0, 8'h00, 8'h11, 4'd2},  // R2
        '{2'd1, 1'b0, 2'd1, 3'd0, 8'h1F, 1'b0, 8'h00, 8'h5A, 4'd3},  // R3
        '{2'd1, 1'b1, 2'd0, 3'd0, 8'h90, 1'b0, 8'hEE, 8'h00, 4'd7},  // R7
        '{2'd1, 1'b0, 2'd0, 3'd0, 8'h90, 1'b0, 8'h00, 8'h00, 4'd7},  // R7
        '{2'd1, 1'b1, 2'd0, 3'd0, 8'h05, 1'b0, 8'h22, 8'h00, 4'd4},  // R4
        '{2'd0, 1'b1, 2'd2, 3'd1, 8'h00, 1'b0, 8'h85, 8'h00, 4'd7},  // R7 pointer 0x85
        '{2'd2, 1'b0, 2'd2, 3'd0, 8'h00, 1'b1, 8'h00, 8'h00, 4'd7},  // R7
        '{2'd2, 1'b1, 2'd2, 3'd0, 8'h00, 1'b1, 8'h99, 8'h00, 4'd7},  // R7
        '{2'd1, 1'b0, 2'd0, 3'd0, 8'h05, 1'b0, 8'h00, 8'h22, 4'd7},  // R7 byte 0x05 untouched
        '{2'd1, 1'b1, 2'd0, 3'd0, 8'h06, 1'b0, 8'h33, 8'h00, 4'd4},  // R4
        '{2'd0, 1'b0, 2'd1, 3'd5, 8'h00, 1'b0, 8'h00, 8'hA5, 4'd2}   // R2
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = 2'd0;
    logic       req_write = 1'b0;
    logic [2:0] reg_num = 3'd0;
    logic [7:0] dir_addr = 8'h00;
    logic       ptr_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [1:0] bank_sel = 2'd0;
    logic       busy, rd_valid, wr_ack;
    logic [7:0] rd_data;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    bank_ram u_bank_ram (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .req_write (req_write),
        .reg_num   (reg_num),
        .dir_addr  (dir_addr),
        .ptr_sel   (ptr_sel),
        .wdata     (wdata),
        .bank_sel  (bank_sel),
        .busy      (busy),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .wr_ack    (wr_ack)
    );

    task automatic check(input int rq, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_valid = 1'b1;
        req_mode  = v.mode;
        req_write = v.wr;
        reg_num   = v.rn;
        dir_addr  = v.addr;
        ptr_sel   = v.sel;
        wdata     = v.wd;
        bank_sel  = v.bank;
    endtask

    task automatic run_vec(input vec_t v);
        @(negedge clk);
        drive(v);
        @(negedge clk);
        req_valid = 1'b0;
        if (v.mode == 2'd2) begin
            check(6, "busy after pointer accept", {7'd0, busy}, 8'h01);
            @(negedge clk);
        end
        if (v.wr) begin
            check(v.rq, "wr_ack", {7'd0, wr_ack}, 8'h01);
            check(v.rq, "rd_valid on write", {7'd0, rd_valid}, 8'h00);
        end else begin
            check(v.rq, "rd_valid", {7'd0, rd_valid}, 8'h01);
            check(v.rq, "rd_data", rd_data, v.exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check(1, "busy in reset", {7'd0, busy}, 8'h00);
        check(1, "rd_valid in reset", {7'd0, rd_valid}, 8'h00);
        check(1, "wr_ack in reset", {7'd0, wr_ack}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: still quiet after release
        check(1, "outputs after reset", {5'd0, busy, rd_valid, wr_ack}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
        end

        // R6 / R8: pointer read in bank 2, bank switch and direct write during busy
        @(negedge clk);
        drive('{2'd2, 1'b0, 2'd2, 3'd0, 8'h00, 1'b0, 8'h00, 8'h00, 4'd8});
        @(negedge clk);
        check(6, "busy in second cycle", {7'd0, busy}, 8'h01);
        drive('{2'd1, 1'b1, 2'd0, 3'd0, 8'h06, 1'b0, 8'hFF, 8'h00, 4'd6});
        @(negedge clk);
        req_valid = 1'b0;
        check(8, "in-flight result uses old bank", rd_data, 8'h77);
        check(8, "in-flight rd_valid", {7'd0, rd_valid}, 8'h01);
        check(6, "dropped write not acked", {7'd0, wr_ack}, 8'h00);
        check(6, "busy cleared", {7'd0, busy}, 8'h00);
        run_vec('{2'd1, 1'b0, 2'd0, 3'd0, 8'h06, 1'b0, 8'h00, 8'h33, 4'd6});  // R6
        // R8: new bank applies to the next request
        run_vec('{2'd0, 1'b0, 2'd3, 3'd7, 8'h00, 1'b0, 8'h00, 8'h5A, 4'd8});

        // R9: reserved mode has no effect
        @(negedge clk);
        drive('{2'd3, 1'b1, 2'd0, 3'd6, 8'h06, 1'b0, 8'hAB, 8'h00, 4'd9});
        @(negedge clk);
        req_valid = 1'b0;
        check(9, "reserved mode outputs", {5'd0, busy, rd_valid, wr_ack}, 8'h00);
        run_vec('{2'd1, 1'b0, 2'd0, 3'd0, 8'h06, 1'b0, 8'h00, 8'h33, 4'd9});  // R9

        // R10: read result held through idle cycles
        repeat (3) @(negedge clk);
        check(10, "rd_valid idle", {7'd0, rd_valid}, 8'h00);
        check(10, "rd_data held", rd_data, 8'h33);
        run_vec('{2'd1, 1'b1, 2'd0, 3'd0, 8'h07, 1'b0, 8'h44, 8'h00, 4'd10});  // R10
        check(10, "rd_data held over write", rd_data, 8'h33);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule